// File: doc/BRIEF.md
# Byte-wise HDLC FCS-16 generator and checker

This block computes the 16-bit frame check sequence of an HDLC-style frame, consuming one byte per clock. The running value uses the reflected (LSB-first) form of the polynomial x^16+x^12+x^5+1. Each byte update is a table lookup with the table entries computed combinationally, so no table is stored. Framing, flag detection and byte unescaping happen upstream. This block sees only the bytes that lie between the opening and the closing flag.

In transmit mode the block absorbs payload bytes. When the end of the payload is signalled, it offers two trailer bytes on a valid/ready stream. The trailer is the one's complement of the running value, low byte first, then high byte. New payload is held off until both trailer bytes are taken.

In receive mode the block absorbs every byte of the frame, including the two received check bytes. When the end of the frame is signalled, it raises a status: good if the running value equals the fixed residue 16'hF0B8, otherwise bad.

Top module: `fcs16_engine`

## Requirements
- R1: A cycle with `clr_i` high and no accepted byte leaves the running value at 16'hFFFF, so an empty transmit frame yields the trailer bytes 8'h00, 8'h00.
- R2: Each accepted byte (`in_valid_i` and `in_ready_o` high) replaces the running value F with T(d XOR F[7:0]) XOR (F >> 8). T(i) is i shifted right eight times; after each shift it is XORed with 16'h8408 whenever the bit shifted out was 1.
- R3: In transmit mode (`mode_i` = 1), an `end_i` pulse with no byte offered and no `clr_i` starts the trailer. The first byte is ~F[7:0] and the second is ~F[15:8].
- R4: While a trailer byte is not taken, `tr_valid_o` stays high and `tr_data_o` stays unchanged. `in_ready_o` is low from the end request until the second trailer byte is taken. A byte offered in that time is dropped and does not change the trailer.
- R5: In receive mode (`mode_i` = 0), an `end_i` pulse with no byte offered and no `clr_i` raises `stat_valid_o` in the next cycle. `stat_good_o` rises with it if the running value is 16'hF0B8; otherwise `stat_bad_o` rises. The two are never high together.
- R6: When `clr_i` arrives together with an accepted byte, the block restarts from 16'hFFFF and then applies that byte.
- R7: `clr_i` during a trailer aborts it. `tr_valid_o` is low in the next cycle and `in_ready_o` is high.
- R8: The nine-byte ASCII string "123456789" sent in transmit mode yields the trailer bytes 8'h6E, 8'h90.
- R9: The receive status stays held until a `clr_i` or an accepted byte, which lowers all three status outputs in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Frame start: reload the running value, abort a trailer, clear the status |
| mode_i | input | 1 | 1 = transmit, 0 = receive |
| in_valid_i | input | 1 | Byte offered |
| in_ready_o | output | 1 | Byte can be taken (low during a trailer) |
| in_data_i | input | 8 | Frame byte |
| end_i | input | 1 | End of payload (transmit) or end of frame (receive); honoured only with no byte offered |
| tr_valid_o | output | 1 | Trailer byte offered |
| tr_ready_i | input | 1 | Trailer byte taken |
| tr_data_o | output | 8 | Trailer byte |
| stat_valid_o | output | 1 | Receive status present |
| stat_good_o | output | 1 | Frame ended on the good residue |
| stat_bad_o | output | 1 | Frame ended on any other value |

## Verification
On every cycle the assertions check the following. A clear reloads the initial value. The trailer holds its byte and its running value under backpressure. The low byte is followed by the high byte. No byte is taken during a trailer. A clear kills the trailer. The good and bad status outputs are exclusive.

The arithmetic itself can only be shown by the bench's scenarios. The bench sweeps all 256 single-byte frames through transmit, then receive with the true trailer, then receive with a corrupted trailer. It compares against a bit-serial model. Those scenarios also cover the known check string, a clear combined with a byte, dropped bytes under backpressure, and status clearing.

// File: rtl/fcs16_pkg.sv
package fcs16_pkg;
  localparam int BYTE_W = 8;
  localparam int FCS_W  = 16;

  typedef enum logic [1:0] {
    TS_PAYLOAD = 2'd0,
    TS_LOW     = 2'd1,
    TS_HIGH    = 2'd2
  } trl_state_t;

  // One entry of the reflected byte table, computed on demand.
  function automatic logic [FCS_W-1:0] fcs_table(input logic [BYTE_W-1:0] idx,
                                                 input logic [FCS_W-1:0] poly);
    logic [FCS_W-1:0] acc;
    acc = {{(FCS_W-BYTE_W){1'b0}}, idx};
    for (int i = 0; i < BYTE_W; i++) begin
      if (acc[0]) acc = (acc >> 1) ^ poly;
      else        acc = acc >> 1;
    end
    return acc;
  endfunction

  // Byte step: table word, with the old high byte folded into its low byte.
  function automatic logic [FCS_W-1:0] fcs_step(input logic [FCS_W-1:0] fcs,
                                                input logic [BYTE_W-1:0] data,
                                                input logic [FCS_W-1:0] poly);
    return fcs_table(data ^ fcs[BYTE_W-1:0], poly) ^ (fcs >> BYTE_W);
  endfunction
endpackage

// File: rtl/fcs16_datapath.sv
module fcs16_datapath
  import fcs16_pkg::*;
#(
  parameter logic [FCS_W-1:0] POLY = 16'h8408,
  parameter logic [FCS_W-1:0] INIT = 16'hFFFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              take_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic [FCS_W-1:0]  fcs_o
);
  logic [FCS_W-1:0] fcs_q;
  logic [FCS_W-1:0] base;
  logic [FCS_W-1:0] fcs_d;

  assign base = clr_i ? INIT : fcs_q;

  always_comb begin
    if (take_i) fcs_d = fcs_step(base, data_i, POLY);
    else        fcs_d = base;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fcs_q <= INIT;
    else         fcs_q <= fcs_d;
  end

  assign fcs_o = fcs_q;
endmodule

// File: rtl/fcs16_trailer.sv
module fcs16_trailer
  import fcs16_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              start_i,
  input  logic              tr_ready_i,
  input  logic [FCS_W-1:0]  fcs_i,
  output logic              payload_o,
  output logic              tr_valid_o,
  output logic              tr_low_o,
  output logic [BYTE_W-1:0] tr_data_o
);
  trl_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (clr_i) begin
      state_d = TS_PAYLOAD;
    end else begin
      unique case (state_q)
        TS_PAYLOAD: if (start_i)    state_d = TS_LOW;
        TS_LOW:     if (tr_ready_i) state_d = TS_HIGH;
        TS_HIGH:    if (tr_ready_i) state_d = TS_PAYLOAD;
        default:                    state_d = TS_PAYLOAD;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= TS_PAYLOAD;
    else         state_q <= state_d;
  end

  assign payload_o  = (state_q == TS_PAYLOAD);
  assign tr_valid_o = !payload_o;
  assign tr_low_o   = (state_q == TS_LOW);
  assign tr_data_o  = tr_low_o ? ~fcs_i[BYTE_W-1:0] : ~fcs_i[FCS_W-1:BYTE_W];
endmodule

// File: rtl/fcs16_status.sv
module fcs16_status
  import fcs16_pkg::*;
#(
  parameter logic [FCS_W-1:0] RESIDUE = 16'hF0B8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             take_i,
  input  logic             check_i,
  input  logic [FCS_W-1:0] fcs_i,
  output logic             stat_valid_o,
  output logic             stat_good_o,
  output logic             stat_bad_o
);
  logic valid_q;
  logic match_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      match_q <= 1'b0;
    end else if (clr_i || take_i) begin
      valid_q <= 1'b0;
      match_q <= 1'b0;
    end else if (check_i) begin
      valid_q <= 1'b1;
      match_q <= (fcs_i == RESIDUE);
    end
  end

  assign stat_valid_o = valid_q;
  assign stat_good_o  = valid_q && match_q;
  assign stat_bad_o   = valid_q && !match_q;
endmodule

// File: rtl/fcs16_engine.sv
module fcs16_engine
  import fcs16_pkg::*;
#(
  parameter logic [15:0] POLY    = 16'h8408,
  parameter logic [15:0] INIT    = 16'hFFFF,
  parameter logic [15:0] RESIDUE = 16'hF0B8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       mode_i,
  input  logic       in_valid_i,
  output logic       in_ready_o,
  input  logic [7:0] in_data_i,
  input  logic       end_i,
  output logic       tr_valid_o,
  input  logic       tr_ready_i,
  output logic [7:0] tr_data_o,
  output logic       stat_valid_o,
  output logic       stat_good_o,
  output logic       stat_bad_o
);
  logic [FCS_W-1:0] fcs_q;
  logic             payload;
  logic             trl_low;
  logic             take;
  logic             end_ok;
  logic             tx_start;
  logic             rx_check;

  // Named events shared by the sub-blocks and the checker.
  assign take     = in_valid_i && payload;
  assign end_ok   = end_i && !in_valid_i && !clr_i && payload;
  assign tx_start = end_ok && mode_i;
  assign rx_check = end_ok && !mode_i;

  fcs16_datapath #(.POLY(POLY), .INIT(INIT)) u_dp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_i),
    .take_i (take),
    .data_i (in_data_i),
    .fcs_o  (fcs_q)
  );

  fcs16_trailer u_trl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr_i),
    .start_i    (tx_start),
    .tr_ready_i (tr_ready_i),
    .fcs_i      (fcs_q),
    .payload_o  (payload),
    .tr_valid_o (tr_valid_o),
    .tr_low_o   (trl_low),
    .tr_data_o  (tr_data_o)
  );

  fcs16_status #(.RESIDUE(RESIDUE)) u_st (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clr_i        (clr_i),
    .take_i       (take),
    .check_i      (rx_check),
    .fcs_i        (fcs_q),
    .stat_valid_o (stat_valid_o),
    .stat_good_o  (stat_good_o),
    .stat_bad_o   (stat_bad_o)
  );

  assign in_ready_o = payload;
endmodule

// File: rtl/fcs16_engine_checker.sv
module fcs16_engine_checker #(
  parameter logic [15:0] INIT = 16'hFFFF
) (
  input logic        clk,
  input logic        rst_n,
  input logic        clr,
  input logic        in_valid,
  input logic        in_ready,
  input logic        tr_valid,
  input logic        tr_ready,
  input logic        tr_low,
  input logic [7:0]  tr_data,
  input logic        stat_valid,
  input logic        stat_good,
  input logic        stat_bad,
  input logic [15:0] fcs_q
);
  AST_CLR_LOADS_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !in_valid) |=> (fcs_q == INIT)); // R1

  AST_TRAILER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (tr_valid && !tr_ready && !clr) |=> (tr_valid && $stable(tr_data))); // R4

  AST_NO_INTAKE_IN_TRAILER: assert property (@(posedge clk) disable iff (!rst_n)
    tr_valid |-> !in_ready); // R4

  AST_LOW_THEN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (tr_valid && tr_low && tr_ready && !clr) |=> (tr_valid && !tr_low)); // R3

  AST_FCS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (tr_valid && !clr) |=> $stable(fcs_q)); // R3

  AST_CLR_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!tr_valid && in_ready)); // R7

  AST_STATUS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(stat_good && stat_bad) && (stat_valid == (stat_good || stat_bad))); // R5
endmodule

bind fcs16_engine fcs16_engine_checker #(.INIT(INIT)) u_chk (
  .clk        (clk_i),
  .rst_n      (rst_ni),
  .clr        (clr_i),
  .in_valid   (in_valid_i),
  .in_ready   (in_ready_o),
  .tr_valid   (tr_valid_o),
  .tr_ready   (tr_ready_i),
  .tr_low     (trl_low),
  .tr_data    (tr_data_o),
  .stat_valid (stat_valid_o),
  .stat_good  (stat_good_o),
  .stat_bad   (stat_bad_o),
  .fcs_q      (fcs_q)
);

// File: tb/fcs16_engine_bench.sv
module fcs16_engine_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr = 1'b0;
  logic       mode = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = 8'h00;
  logic       end_req = 1'b0;
  logic       tr_valid;
  logic       tr_ready = 1'b0;
  logic [7:0] tr_data;
  logic       stat_valid, stat_good, stat_bad;

  int checks = 0;
  int errors = 0;
  logic [7:0] lo_b, hi_b;
  logic [15:0] model;

  always #5 clk = ~clk;

  fcs16_engine u_fcs16_engine (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .mode_i(mode),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data),
    .end_i(end_req), .tr_valid_o(tr_valid), .tr_ready_i(tr_ready),
    .tr_data_o(tr_data), .stat_valid_o(stat_valid), .stat_good_o(stat_good),
    .stat_bad_o(stat_bad)
  );

  // Bit-serial restatement of the reflected update.
  function automatic logic [15:0] ser_step(input logic [15:0] f, input logic [7:0] d);
    logic [15:0] r;
    logic fb;
    r = f;
    for (int b = 0; b < 8; b++) begin
      fb = r[0] ^ d[b];
      r  = r >> 1;
      if (fb) r = r ^ 16'h8408;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_clr();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic send(input logic [7:0] d, input logic with_clr);
    @(negedge clk); in_valid = 1'b1; in_data = d; clr = with_clr;
    @(negedge clk); in_valid = 1'b0; clr = 1'b0;
  endtask

  task automatic pulse_end();
    @(negedge clk); end_req = 1'b1;
    @(negedge clk); end_req = 1'b0;
  endtask

  // Called at the negedge right after the end pulse; takes both bytes.
  task automatic grab_trailer(output logic [7:0] lo, output logic [7:0] hi);
    lo = tr_data; tr_ready = 1'b1;
    @(negedge clk); hi = tr_data;
    @(negedge clk); tr_ready = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // Reset state
    check("R4 reset in_ready", {31'd0, in_ready}, 32'd1);
    check("R4 reset tr_valid", {31'd0, tr_valid}, 32'd0);
    check("R5 reset stat_valid", {31'd0, stat_valid}, 32'd0);
    rst_n = 1'b1;

    // R1: empty transmit frame
    mode = 1'b1;
    do_clr();
    pulse_end();
    check("R3 trailer valid", {31'd0, tr_valid}, 32'd1);
    check("R4 in_ready low in trailer", {31'd0, in_ready}, 32'd0);
    grab_trailer(lo_b, hi_b);
    check("R1 empty lo", {24'd0, lo_b}, 32'h00);
    check("R1 empty hi", {24'd0, hi_b}, 32'h00);
    check("R4 in_ready back", {31'd0, in_ready}, 32'd1);
    check("R4 trailer gone", {31'd0, tr_valid}, 32'd0);

    // R8: check string, first byte carried with clear (R6)
    send(8'h31, 1'b1);
    for (int k = 2; k <= 9; k++) send(8'h30 + 8'(k), 1'b0);
    pulse_end();
    grab_trailer(lo_b, hi_b);
    check("R8 check lo", {24'd0, lo_b}, 32'h6E);
    check("R8 check hi", {24'd0, hi_b}, 32'h90);

    // R2/R3/R5/R6: sweep all single-byte frames
    for (int v = 0; v < 256; v++) begin
      model = ser_step(16'hFFFF, 8'(v));
      mode = 1'b1;
      send(8'hA5, 1'b1);          // junk, discarded by the next clear
      send(8'(v), 1'b1);          // R6: clear together with the byte
      pulse_end();
      grab_trailer(lo_b, hi_b);
      check("R2 R3 R6 sweep lo", {24'd0, lo_b}, {24'd0, ~model[7:0]});
      check("R2 R3 sweep hi", {24'd0, hi_b}, {24'd0, ~model[15:8]});
      mode = 1'b0;
      send(8'(v), 1'b1);
      send(~model[7:0], 1'b0);
      send(~model[15:8], 1'b0);
      pulse_end();
      check("R5 good", {30'd0, stat_valid, stat_good}, 32'd3);
      send(8'(v), 1'b1);
      check("R9 cleared by byte", {29'd0, stat_valid, stat_good, stat_bad}, 32'd0);
      send(~model[7:0], 1'b0);
      send(~model[15:8] ^ 8'h01, 1'b0);
      pulse_end();
      check("R5 bad", {29'd0, stat_valid, stat_good, stat_bad}, 32'd5);
    end

    // R9: status held, then cleared by clr
    repeat (3) @(negedge clk);
    check("R9 held", {29'd0, stat_valid, stat_good, stat_bad}, 32'd5);
    do_clr();
    check("R9 cleared by clr", {29'd0, stat_valid, stat_good, stat_bad}, 32'd0);

    // R4: backpressure and a dropped byte during the trailer
    mode = 1'b1;
    send(8'h3C, 1'b1);
    model = ser_step(16'hFFFF, 8'h3C);
    pulse_end();
    repeat (3) @(negedge clk);
    check("R4 hold lo", {24'd0, tr_data}, {24'd0, ~model[7:0]});
    in_valid = 1'b1; in_data = 8'h77;
    @(negedge clk); in_valid = 1'b0;
    check("R4 still valid", {31'd0, tr_valid}, 32'd1);
    grab_trailer(lo_b, hi_b);
    check("R4 dropped byte lo", {24'd0, lo_b}, {24'd0, ~model[7:0]});
    check("R4 dropped byte hi", {24'd0, hi_b}, {24'd0, ~model[15:8]});

    // R7: clear aborts a trailer
    send(8'h11, 1'b1);
    pulse_end();
    check("R7 trailer up", {31'd0, tr_valid}, 32'd1);
    do_clr();
    check("R7 aborted valid", {31'd0, tr_valid}, 32'd0);
    check("R7 aborted ready", {31'd0, in_ready}, 32'd1);
    pulse_end();
    grab_trailer(lo_b, hi_b);
    check("R7 R1 restart lo", {24'd0, lo_b}, 32'h00);
    check("R7 R1 restart hi", {24'd0, hi_b}, 32'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule